// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Read Latch

This block keeps wall-clock time in BCD as tenths of seconds, seconds, minutes and a 12-hour hour field with an AM/PM flag. A one-cycle strobe on `tick` marks each period of a 60 Hz mains reference, and six strobes make one tenth of a second. The time is reached as four byte registers on a small synchronous peripheral bus, at offsets 0x8 (tenths), 0x9 (seconds), 0xA (minutes) and 0xB (hours).

A processor reads the time as several separate bytes. Reading the hour byte takes a snapshot of all four fields, and the following reads return that snapshot while the counters keep running. Reading the tenths byte releases the snapshot. When software sets the time, a write to the hour byte stops the count and a write to the tenths byte starts it again. While `alarm_sel` is high, writes go to a set of alarm registers instead of the time. When the running time becomes equal to the alarm, the block raises a one-cycle event that drives bit 2 of an interrupt status register outside this block.

Top module: `tod_clock`

## Requirements
- R1: After reset the time is 12:00:00.0 AM. The reads return 0x12 at offset 0xB and 0x00 at offsets 0xA, 0x9 and 0x8, and `alarm_evt` is low.
- R2: Every sixth `tick` strobe adds one to the tenths field, in the clock cycle that samples that strobe. Five strobes leave the tenths field unchanged.
- R3: Tenths wrap from 9 to 0 and carry into seconds. Seconds wrap from 0x59 to 0x00 and carry into minutes. All fields stay valid BCD.
- R4: Minutes wrap from 0x59 to 0x00 and carry into the hour. The hour steps 0x09 to 0x10 and 0x12 to 0x01. The hour byte holds the hour in bits 4:0 and the PM flag in bit 7 (1 = PM).
- R5: The PM flag toggles only when the hour steps from 0x11 to 0x12, so 11:59:59.9 AM becomes 12:00:00.0 PM and reads 0x92 at offset 0xB.
- R6: A read at 0xB freezes all four read values. Later reads, including the releasing read at 0x8, return the frozen values. After the 0x8 read, reads return the live time.
- R7: A time write at 0xB stops the count, and strobes are ignored until a time write at 0x8. That write restarts the count with the six-strobe divider cleared.
- R8: With `alarm_sel` high, writes at 0x8 to 0xB load the alarm fields. They leave the time unchanged and neither stop nor restart the count.
- R9: `alarm_evt` is high for exactly one cycle, in the cycle after the time becomes equal to the alarm. It stays low while the two remain equal.
- R10: Writes at offsets outside 0x8 to 0xB have no effect, and reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe per period of the 60 Hz reference |
| alarm_sel | input | 1 | When high, writes go to the alarm fields |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the same cycle as `rd` |
| alarm_evt | output | 1 | One-cycle alarm match event |

## Verification
`rdata` is combinational, so the bench compares a read's value in the same cycle as `rd`. The read's side effect (taking or releasing the snapshot) takes effect at the clock edge that ends that cycle. A sixth strobe changes the time at the edge that samples it, so reads issued on the next cycle already show the new count. `alarm_evt` follows one register later and is checked at the falling edge just after that sixth strobe, and again one cycle later to confirm it is low.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef struct packed {
    logic       pm;
    logic [4:0] hr;
    logic [6:0] mn;
    logic [6:0] sc;
    logic [3:0] ts;
  } tod_t;

  localparam int NUM_FIELDS = 4;

  // Next value of a 00..59 BCD field; bit 7 is the wrap flag.
  function automatic logic [7:0] bcd60_next(input logic [6:0] v);
    if (v == 7'h59)          return 8'h80;
    else if (v[3:0] == 4'h9) return {1'b0, v[6:4] + 3'd1, 4'h0};
    else                     return {1'b0, v[6:4], v[3:0] + 4'd1};
  endfunction

  // Next 12-hour BCD hour; bit 5 asks for a PM toggle.
  function automatic logic [5:0] hour_next(input logic [4:0] h);
    if (h == 5'h12)      return {1'b0, 5'h01};
    else if (h == 5'h11) return {1'b1, 5'h12};
    else if (h == 5'h09) return {1'b0, 5'h10};
    else                 return {1'b0, h + 5'd1};
  endfunction

  // Byte view of one field; idx 0 = tenths .. 3 = hour.
  function automatic logic [7:0] field_byte(input tod_t t, input logic [1:0] idx);
    case (idx)
      2'd0:    return {4'h0, t.ts};
      2'd1:    return {1'b0, t.sc};
      2'd2:    return {1'b0, t.mn};
      default: return {t.pm, 2'b00, t.hr};
    endcase
  endfunction

  // Load one byte into one field of a time value.
  function automatic tod_t field_load(input tod_t t, input logic [1:0] idx,
                                      input logic [7:0] d);
    tod_t r;
    r = t;
    case (idx)
      2'd0:    r.ts = d[3:0];
      2'd1:    r.sc = d[6:0];
      2'd2:    r.mn = d[6:0];
      default: begin r.pm = d[7]; r.hr = d[4:0]; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tod_prescale.sv
module tod_prescale #(
  parameter int TICKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic step
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  assign step = tick & ~clr & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)   cnt <= '0;
    else if (tick)       cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  assert_clr_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/tod_chain.sv
module tod_chain
  import tod_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step,
  input  logic [NUM_FIELDS-1:0] ld_en,
  input  logic [7:0]            ld_data,
  output tod_t                  now
);
  logic [7:0] sc_nx, mn_nx;
  logic [5:0] hr_nx;
  logic       ts_wrap, sc_wrap, mn_wrap;
  tod_t       stepped, loaded;

  always_comb begin
    sc_nx   = bcd60_next(now.sc);
    mn_nx   = bcd60_next(now.mn);
    hr_nx   = hour_next(now.hr);
    ts_wrap = (now.ts == 4'h9);
    sc_wrap = ts_wrap & sc_nx[7];
    mn_wrap = sc_wrap & mn_nx[7];
    stepped = now;
    stepped.ts = ts_wrap ? 4'h0 : now.ts + 4'd1;
    if (ts_wrap) stepped.sc = sc_nx[6:0];
    if (sc_wrap) stepped.mn = mn_nx[6:0];
    if (mn_wrap) begin
      stepped.hr = hr_nx[4:0];
      stepped.pm = now.pm ^ hr_nx[5];
    end
    loaded = now;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (ld_en[i]) loaded = field_load(loaded, 2'(i), ld_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      now <= '{pm: 1'b0, hr: 5'h12, mn: 7'h00, sc: 7'h00, ts: 4'h0};
    else if (|ld_en) now <= loaded;
    else if (step)   now <= stepped;
  end

  assert_step_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ld_en == '0) |=> (now.ts != $past(now.ts)));
  assert_bcd_digits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en == '0 && $past(ld_en) == '0) |-> (now.ts <= 4'h9 && now.sc[3:0] <= 4'h9 &&
      now.mn[3:0] <= 4'h9 && now.sc[6:4] <= 3'h5 && now.mn[6:4] <= 3'h5));
  assert_pm_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en == '0 && $past(ld_en) == '0 && now.pm != $past(now.pm)) |-> (now.hr == 5'h12));
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FIELDS-1:0] ld_en,
  input  logic [7:0]            ld_data,
  input  tod_t                  now,
  output logic                  evt
);
  tod_t al, al_nx;
  logic eq, eq_q;

  always_comb begin
    al_nx = al;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (ld_en[i]) al_nx = field_load(al_nx, 2'(i), ld_data);
  end

  assign eq  = (now == al);
  assign evt = eq & ~eq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al   <= '0;
      eq_q <= 1'b0;
    end else begin
      al   <= al_nx;
      eq_q <= eq;
    end
  end

  assert_evt_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int TICKS_PER_TENTH = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       alarm_sel,
  input  logic       rd,
  input  logic       wr,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       alarm_evt
);
  localparam logic [1:0] IDX_TS = 2'd0;
  localparam logic [1:0] IDX_HR = 2'd3;

  logic                  in_win;
  logic [1:0]            idx;
  logic [NUM_FIELDS-1:0] wr_time, wr_alarm;
  logic                  halt, pre_clr, step;
  logic                  rd_hr, rd_ts;
  logic                  snap_v;
  tod_t                  now, snap_q, view;

  assign in_win = (addr[3:2] == 2'b10);
  assign idx    = addr[1:0];

  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) begin
      wr_time[i]  = wr & in_win & ~alarm_sel & (idx == 2'(i));
      wr_alarm[i] = wr & in_win &  alarm_sel & (idx == 2'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               halt <= 1'b0;
    else if (wr_time[IDX_HR]) halt <= 1'b1;
    else if (wr_time[IDX_TS]) halt <= 1'b0;
  end

  assign pre_clr = halt | wr_time[IDX_TS];

  tod_prescale #(.TICKS(TICKS_PER_TENTH)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(pre_clr), .step(step)
  );

  tod_chain u_chain (
    .clk(clk), .rst_n(rst_n), .step(step), .ld_en(wr_time), .ld_data(wdata), .now(now)
  );

  tod_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .ld_en(wr_alarm), .ld_data(wdata), .now(now), .evt(alarm_evt)
  );

  assign rd_hr = rd & in_win & (idx == IDX_HR);
  assign rd_ts = rd & in_win & (idx == IDX_TS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_v <= 1'b0;
      snap_q <= '0;
    end else if (rd_ts) begin
      snap_v <= 1'b0;
    end else if (rd_hr && !snap_v) begin
      snap_v <= 1'b1;
      snap_q <= now;
    end
  end

  assign view  = snap_v ? snap_q : now;
  assign rdata = in_win ? field_byte(view, idx) : 8'h00;

  assert_halt_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && wr_time == '0) |=> $stable(now));
  assert_snap_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_v && !rd_ts) |=> (snap_v && $stable(snap_q)));
  assert_alarm_wr_keeps_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_alarm != '0 && !step) |=> $stable(now));
  assert_outside_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> (rdata == 8'h00));
endmodule

// File: tb/sim_tod_clock.sv
module sim_tod_clock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, alarm_sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       alarm_evt;

  int n_chk = 0, n_fail = 0, evt_cnt = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  tod_clock u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .alarm_sel(alarm_sel), .rd(rd),
                .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata), .alarm_evt(alarm_evt));

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as reads appear
  always @(negedge clk) begin
    if (rd) begin
      if (sb.size() == 0) check(rdata, 8'hxx, "scoreboard empty");
      else begin
        item_t it;
        it = sb.pop_front();
        check(rdata, it.exp, it.tag);
      end
    end
  end

  always @(posedge clk) if (rst_n && alarm_evt) evt_cnt++;

  task automatic rd_exp(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    sb.push_back('{exp: e, tag: tag});
    rd = 1'b1; addr = a;
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d, input logic asel);
    @(posedge clk); #1;
    wr = 1'b1; addr = a; wdata = d; alarm_sel = asel;
    @(posedge clk); #1;
    wr = 1'b0; alarm_sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tick = 1'b1;
      @(posedge clk); #1; tick = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m,
                          input logic [7:0] s, input logic [7:0] t);
    wr_reg(4'hB, h, 1'b0); wr_reg(4'hA, m, 1'b0);
    wr_reg(4'h9, s, 1'b0); wr_reg(4'h8, t, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check({7'h0, alarm_evt}, 8'h00, "R1 alarm_evt low");
    rd_exp(4'hB, 8'h12, "R1 hour"); rd_exp(4'hA, 8'h00, "R1 min");
    rd_exp(4'h9, 8'h00, "R1 sec");  rd_exp(4'h8, 8'h00, "R1 tenths");

    ticks(5); rd_exp(4'h8, 8'h00, "R2 five strobes");
    ticks(1); rd_exp(4'h8, 8'h01, "R2 sixth strobe");

    // halt on hour write, restart on tenths write
    wr_reg(4'hB, 8'h09, 1'b0); wr_reg(4'hA, 8'h59, 1'b0); wr_reg(4'h9, 8'h59, 1'b0);
    ticks(12); rd_exp(4'h9, 8'h59, "R7 halted");
    wr_reg(4'h8, 8'h09, 1'b0);
    ticks(5); rd_exp(4'h9, 8'h59, "R7 divider cleared");
    ticks(1);
    rd_exp(4'hB, 8'h10, "R4 hour 09->10"); rd_exp(4'hA, 8'h00, "R4 min wrap");
    rd_exp(4'h9, 8'h00, "R3 sec wrap");    rd_exp(4'h8, 8'h00, "R3 tenths wrap");

    // snapshot
    rd_exp(4'hB, 8'h10, "R6 latch hour");
    ticks(6);
    rd_exp(4'h8, 8'h00, "R6 frozen tenths");
    rd_exp(4'h8, 8'h01, "R6 live after release");

    set_time(8'h11, 8'h59, 8'h59, 8'h09); ticks(6);
    rd_exp(4'hB, 8'h92, "R5 PM flip"); rd_exp(4'hA, 8'h00, "R5 min");
    rd_exp(4'h9, 8'h00, "R5 sec");     rd_exp(4'h8, 8'h00, "R5 tenths");

    set_time(8'h12, 8'h59, 8'h59, 8'h09); ticks(6);
    rd_exp(4'hB, 8'h01, "R4 hour 12->01 keeps flag"); rd_exp(4'h8, 8'h00, "R4 release");

    // alarm at 01:00:00.2 AM (tenths written first)
    wr_reg(4'h8, 8'h02, 1'b1); wr_reg(4'h9, 8'h00, 1'b1);
    wr_reg(4'hA, 8'h00, 1'b1); wr_reg(4'hB, 8'h01, 1'b1);
    rd_exp(4'hB, 8'h01, "R8 hour untouched"); rd_exp(4'h8, 8'h00, "R8 tenths untouched");
    ticks(6); rd_exp(4'h8, 8'h01, "R8 still running");
    check(evt_cnt[7:0], 8'd0, "R9 no early event");
    ticks(6);
    @(negedge clk); check({7'h0, alarm_evt}, 8'h01, "R9 event on match");
    @(negedge clk); check({7'h0, alarm_evt}, 8'h00, "R9 single cycle");
    ticks(6);
    check(evt_cnt[7:0], 8'd1, "R9 one event");

    // outside window
    wr_reg(4'h3, 8'h55, 1'b0); wr_reg(4'hC, 8'h07, 1'b0);
    rd_exp(4'h3, 8'h00, "R10 read outside");
    rd_exp(4'hC, 8'h00, "R10 read outside high");
    rd_exp(4'h8, 8'h03, "R10 time unchanged");

    repeat (2) @(posedge clk);
    check(8'(sb.size()), 8'd0, "scoreboard drained");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule